// File: doc/BRIEF.md
# Conductance-Based Leaky Integrate-and-Fire Neuron Array

This block advances a population of leaky integrate-and-fire neurons by one simulation time step each time it receives a step strobe. Each neuron has an excitatory and an inhibitory synaptic conductance. The synaptic current is the product of each conductance and the gap between the membrane potential and that synapse's reversal potential. A leak current pulls the membrane toward its resting level. The membrane is advanced by one forward Euler step, and a neuron fires when its new potential rises above its own adaptive threshold.

Only a few physical update cores are built. They are shared over all logical neurons in consecutive stages, one stage per clock cycle. Neuron state lives in a local state bank: potential, both conductances and the threshold. All values are signed fixed point with 16 integer and 9 fraction bits. Every constant factor is a power-of-two shift, and only the two conductance-by-voltage products use real multipliers. The block that accumulates synaptic weights supplies the excitatory drive and the inhibitory input of every neuron. It holds them steady until the step-done pulse.

Top module: `cond_lif_array`

## Requirements
- R1: While reset is high, and after it until the first step, all spike flags and the done flag are 0. Every neuron starts with v = V_REST, both conductances 0 and threshold THETA_INIT.
- R2: A step strobe taken while idle starts one time step. Strobes that arrive while a step is in progress are ignored and do not start another step.
- R3: The step takes STAGES = N_NEURONS/N_CORES stages, one per cycle. In stage s, core c updates neuron s*N_CORES + c, using drive field k (bits k*25 and up) of each drive bus for neuron k.
- R4: Each conductance first decays by its own shift, g - (g >>> SHIFT). Then the neuron's drive is added to it.
- R5: The new potential is v + ((((V_REST - v) >>> LEAK_SHIFT) + ((ge*(E_EXC - v)) >>> 9) + ((gi*(E_INH - v)) >>> 9)) >>> DT_SHIFT). It is computed with the updated conductances, and all shifts are arithmetic.
- R6: A neuron fires in a step only when its new potential is strictly greater than its current threshold. Its spike flag then shows the result of that step.
- R7: A neuron that fires has its potential set to V_REST and its threshold raised by THETA_INC. A threshold never decreases.
- R8: Every state update saturates at -2^24 and 2^24-1 instead of wrapping.
- R9: The done flag is a single-cycle pulse that appears STAGES cycles after the edge that took the strobe, once every stage has written back. Spike flags hold their values between steps, whatever the drive inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Strobe that starts one time step |
| exc_drive_i | input | N_NEURONS*25 | Signed excitatory drive per neuron, Q16.9 |
| inh_drive_i | input | N_NEURONS*25 | Signed inhibitory input per neuron, Q16.9 |
| spike_o | output | N_NEURONS | Per-neuron fired flag for the last step |
| step_done_o | output | 1 | One-cycle pulse when all stages are written back |

## Verification
A zero-drive step separates a correct leak and rest point from a core that moves the membrane on its own. A uniformly strong excitatory step makes every neuron fire and exposes the reset and threshold increment on the following steps. Distinct random drives per neuron, over many chained steps, show up any mistake in the neuron-to-core-and-stage mapping and any rounding difference in the multiplier and shift path. Extreme inhibitory and excitatory drives push the conductances and the potential to the fixed-point limits, where saturation and wrapping lead to different spike patterns afterwards. A second strobe during a running step shows whether busy strobes are really ignored.

// File: rtl/cond_lif_pkg.sv
package cond_lif_pkg;

    localparam int FX_INT  = 16;
    localparam int FX_FRAC = 9;
    localparam int FX_W    = FX_INT + FX_FRAC;
    localparam int WIDE_W  = 64;

    typedef logic signed [FX_W-1:0]   fx_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam wide_t FX_MAX = (wide_t'(1) <<< (FX_W - 1)) - wide_t'(1);
    localparam wide_t FX_MIN = -(wide_t'(1) <<< (FX_W - 1));

    // Per-neuron state held in the bank
    typedef struct packed {
        fx_t v;
        fx_t ge;
        fx_t gi;
        fx_t theta;
    } nstate_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_t;

    function automatic wide_t widen(input fx_t a);
        return wide_t'(a);
    endfunction

    function automatic fx_t fx_sat(input wide_t x);
        if (x > FX_MAX) return fx_t'(FX_MAX);
        if (x < FX_MIN) return fx_t'(FX_MIN);
        return fx_t'(x);
    endfunction

endpackage

// File: rtl/lif_euler_unit.sv
module lif_euler_unit
    import cond_lif_pkg::*;
#(
    parameter int V_REST     = -33280,
    parameter int E_EXC      = 0,
    parameter int E_INH      = -51200,
    parameter int THETA_INC  = 512,
    parameter int LEAK_SHIFT = 3,
    parameter int DT_SHIFT   = 2,
    parameter int GE_SHIFT   = 2,
    parameter int GI_SHIFT   = 1
) (
    input  nstate_t cur_i,
    input  fx_t     exc_i,
    input  fx_t     inh_i,
    output nstate_t nxt_o,
    output logic    fire_o
);

    localparam wide_t W_REST = wide_t'(V_REST);
    localparam wide_t W_EEXC = wide_t'(E_EXC);
    localparam wide_t W_EINH = wide_t'(E_INH);
    localparam wide_t W_TINC = wide_t'(THETA_INC);

    wide_t v_w, ge_w, gi_w, th_w;
    fx_t   ge_n, gi_n, v_n;
    wide_t i_exc, i_inh, i_leak, dv;

    always_comb begin
        v_w  = widen(cur_i.v);
        ge_w = widen(cur_i.ge);
        gi_w = widen(cur_i.gi);
        th_w = widen(cur_i.theta);

        // conductance decay then drive injection (R4)
        ge_n = fx_sat(ge_w - (ge_w >>> GE_SHIFT) + widen(exc_i));
        gi_n = fx_sat(gi_w - (gi_w >>> GI_SHIFT) + widen(inh_i));

        // synaptic and leak currents, Euler step (R5)
        i_exc  = (widen(ge_n) * (W_EEXC - v_w)) >>> FX_FRAC;
        i_inh  = (widen(gi_n) * (W_EINH - v_w)) >>> FX_FRAC;
        i_leak = (W_REST - v_w) >>> LEAK_SHIFT;
        dv     = (i_leak + i_exc + i_inh) >>> DT_SHIFT;
        v_n    = fx_sat(v_w + dv);

        // threshold crossing, reset and adaptation (R6, R7)
        fire_o    = (widen(v_n) > th_w);
        nxt_o.ge  = ge_n;
        nxt_o.gi  = gi_n;
        if (fire_o) begin
            nxt_o.v     = fx_t'(W_REST);
            nxt_o.theta = fx_sat(th_w + W_TINC);
        end else begin
            nxt_o.v     = v_n;
            nxt_o.theta = cur_i.theta;
        end
    end

endmodule

// File: rtl/lif_stage_seq.sv
module lif_stage_seq
    import cond_lif_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int STG_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic             we_o,
    output logic [STG_W-1:0] stage_o,
    output logic             done_o
);

    localparam logic [STG_W-1:0] LAST = STG_W'(STAGES - 1);

    seq_t             state_q;
    logic [STG_W-1:0] stage_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            stage_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (step_i) begin
                        state_q <= SEQ_RUN;
                        stage_q <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (stage_q == LAST) begin
                        state_q <= SEQ_IDLE;
                        stage_q <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        stage_q <= stage_q + STG_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign we_o    = (state_q == SEQ_RUN);
    assign stage_o = stage_q;
    assign done_o  = done_q;

    assert_stage_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |-> (int'(stage_q) < STAGES));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(state_q == SEQ_RUN && stage_q == LAST));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/lif_state_bank.sv
module lif_state_bank
    import cond_lif_pkg::*;
#(
    parameter int N_CORES    = 4,
    parameter int N_NEURONS  = 16,
    parameter int STG_W      = 2,
    parameter int V_REST     = -33280,
    parameter int THETA_INIT = -26624
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [STG_W-1:0] stage_i,
    input  nstate_t          wr_state_i [N_CORES],
    input  logic             wr_fire_i  [N_CORES],
    output nstate_t          rd_state_o [N_CORES],
    output logic [N_NEURONS-1:0] spike_o
);

    localparam int IDX_W = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1;

    nstate_t              mem [N_NEURONS];
    logic [N_NEURONS-1:0] spike_q;
    logic [IDX_W-1:0]     base_idx;

    assign base_idx = IDX_W'(int'(stage_i) * N_CORES);

    always_comb begin
        for (int c = 0; c < N_CORES; c++) begin
            rd_state_o[c] = mem[base_idx + IDX_W'(c)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_NEURONS; k++) begin
                mem[k].v     <= fx_t'(V_REST);
                mem[k].ge    <= '0;
                mem[k].gi    <= '0;
                mem[k].theta <= fx_t'(THETA_INIT);
            end
            spike_q <= '0;
        end else if (we_i) begin
            for (int c = 0; c < N_CORES; c++) begin
                mem[base_idx + IDX_W'(c)]     <= wr_state_i[c];
                spike_q[base_idx + IDX_W'(c)] <= wr_fire_i[c];
            end
        end
    end

    assign spike_o = spike_q;

    assert_rest_after_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (we_i && wr_fire_i[0]) |=> (mem[$past(base_idx)].v == fx_t'(V_REST)));

    assert_theta_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        mem[0].theta >= $past(mem[0].theta));

endmodule

// File: rtl/cond_lif_array.sv
module cond_lif_array
    import cond_lif_pkg::*;
#(
    parameter int N_CORES    = 4,
    parameter int N_NEURONS  = 16,
    parameter int V_REST     = -33280,
    parameter int E_EXC      = 0,
    parameter int E_INH      = -51200,
    parameter int THETA_INIT = -26624,
    parameter int THETA_INC  = 512,
    parameter int LEAK_SHIFT = 3,
    parameter int DT_SHIFT   = 2,
    parameter int GE_SHIFT   = 2,
    parameter int GI_SHIFT   = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step_i,
    input  logic [N_NEURONS*25-1:0]   exc_drive_i,
    input  logic [N_NEURONS*25-1:0]   inh_drive_i,
    output logic [N_NEURONS-1:0]      spike_o,
    output logic                      step_done_o
);

    localparam int STAGES = N_NEURONS / N_CORES;
    localparam int STG_W  = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic             we;
    logic [STG_W-1:0] stage;
    nstate_t          rd_state [N_CORES];
    nstate_t          wr_state [N_CORES];
    logic             wr_fire  [N_CORES];

    lif_stage_seq #(
        .STAGES (STAGES),
        .STG_W  (STG_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_i),
        .we_o    (we),
        .stage_o (stage),
        .done_o  (step_done_o)
    );

    lif_state_bank #(
        .N_CORES    (N_CORES),
        .N_NEURONS  (N_NEURONS),
        .STG_W      (STG_W),
        .V_REST     (V_REST),
        .THETA_INIT (THETA_INIT)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .we_i       (we),
        .stage_i    (stage),
        .wr_state_i (wr_state),
        .wr_fire_i  (wr_fire),
        .rd_state_o (rd_state),
        .spike_o    (spike_o)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        fx_t exc_sel, inh_sel;
        int  nidx;

        always_comb begin
            nidx    = int'(stage) * N_CORES + c;
            exc_sel = fx_t'(exc_drive_i[nidx*FX_W +: FX_W]);
            inh_sel = fx_t'(inh_drive_i[nidx*FX_W +: FX_W]);
        end

        lif_euler_unit #(
            .V_REST     (V_REST),
            .E_EXC      (E_EXC),
            .E_INH      (E_INH),
            .THETA_INC  (THETA_INC),
            .LEAK_SHIFT (LEAK_SHIFT),
            .DT_SHIFT   (DT_SHIFT),
            .GE_SHIFT   (GE_SHIFT),
            .GI_SHIFT   (GI_SHIFT)
        ) u_unit (
            .cur_i  (rd_state[c]),
            .exc_i  (exc_sel),
            .inh_i  (inh_sel),
            .nxt_o  (wr_state[c]),
            .fire_o (wr_fire[c])
        );
    end

endmodule

// File: tb/cond_lif_array_tb.sv
module cond_lif_array_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NN = 16;
    localparam int S  = NN / NC;
    localparam int W  = 25;
    localparam longint MAXV = (longint'(1) <<< 24) - 1;
    localparam longint MINV = -(longint'(1) <<< 24);
    localparam longint VR = -33280, EE = 0, EI = -51200;
    localparam longint TH0 = -26624, TINC = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0;
    logic [NN*W-1:0] exc = '0;
    logic [NN*W-1:0] inh = '0;
    logic [NN-1:0] spk;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    longint mv [NN], mge [NN], mgi [NN], mth [NN];
    longint de [NN], di [NN];
    logic [NN-1:0] exp_spk;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_lif_array u_dut (
        .clk(clk), .rst(rst), .step_i(step),
        .exc_drive_i(exc), .inh_drive_i(inh),
        .spike_o(spk), .step_done_o(done)
    );

    function automatic longint sat(input longint x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // R4, R5, R6, R7, R8 reference model
    task automatic model_step();
        for (int k = 0; k < NN; k++) begin
            longint ge, gi, ie, ii, il, dv, vn;
            ge = sat(mge[k] - (mge[k] >>> 2) + de[k]);
            gi = sat(mgi[k] - (mgi[k] >>> 1) + di[k]);
            ie = (ge * (EE - mv[k])) >>> 9;
            ii = (gi * (EI - mv[k])) >>> 9;
            il = (VR - mv[k]) >>> 3;
            dv = (il + ie + ii) >>> 2;
            vn = sat(mv[k] + dv);
            mge[k] = ge;
            mgi[k] = gi;
            exp_spk[k] = (vn > mth[k]);
            if (exp_spk[k]) begin
                mv[k] = VR;
                mth[k] = sat(mth[k] + TINC);
            end else begin
                mv[k] = vn;
            end
        end
    endtask

    task automatic apply_drives();
        for (int k = 0; k < NN; k++) begin
            exc[k*W +: W] = W'(de[k]);
            inh[k*W +: W] = W'(di[k]);
        end
    endtask

    task automatic run_step(input bit strobe_again);
        int lat;
        int ndone;
        logic [NN-1:0] held;
        // R9: flags hold while drives change without a strobe
        held = spk;
        @(negedge clk);
        exc = {NN{25'h0ABCD}};
        inh = {NN{25'h1F000}};
        repeat (3) @(negedge clk);
        check(spk == held, "R9 hold", longint'(spk), longint'(held));
        apply_drives();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        lat = -1;
        ndone = 0;
        for (int k = 1; k <= S + 4; k++) begin
            @(negedge clk);
            if (strobe_again && k == 1) step = 1'b1;
            if (k == 2) step = 1'b0;
            if (done) begin
                ndone++;
                if (lat < 0) lat = k;
            end
        end
        model_step();
        check(lat == S, "R3/R9 latency", longint'(lat), longint'(S));
        check(ndone == 1, strobe_again ? "R2 busy strobe" : "R9 pulse", longint'(ndone), 1);
        check(spk == exp_spk, "R6 spikes", longint'(spk), longint'(exp_spk));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NN; k++) begin
            mv[k] = VR; mge[k] = 0; mgi[k] = 0; mth[k] = TH0;
            de[k] = 0; di[k] = 0;
        end
        repeat (3) @(negedge clk);
        check(spk == '0, "R1 spikes in reset", longint'(spk), 0);
        check(done == 1'b0, "R1 done in reset", longint'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(spk == '0 && done == 1'b0, "R1 after reset", longint'({done, spk}), 0);

        // R5 zero drive: rest point is stable
        run_step(1'b0);
        // R7 strong uniform excitation: all fire
        for (int k = 0; k < NN; k++) begin de[k] = 2000; di[k] = 0; end
        run_step(1'b0);
        check(spk == '1, "R7 all fire", longint'(spk), longint'('1));
        // R2 busy strobe ignored
        for (int k = 0; k < NN; k++) begin de[k] = 300 + 20 * k; di[k] = 40; end
        run_step(1'b1);
        // R8 saturating inhibition then excitation
        for (int k = 0; k < NN; k++) begin de[k] = 0; di[k] = MAXV; end
        run_step(1'b0);
        for (int k = 0; k < NN; k++) begin de[k] = 500; di[k] = MINV; end
        run_step(1'b0);
        // R8 saturating excitation
        for (int k = 0; k < NN; k++) begin de[k] = MAXV; di[k] = 0; end
        run_step(1'b0);
        run_step(1'b0);
        // R3 distinct per-neuron random drives
        for (int t = 0; t < 60; t++) begin
            for (int k = 0; k < NN; k++) begin
                de[k] = longint'($urandom_range(0, 700));
                di[k] = longint'($urandom_range(0, 250));
                if ($urandom_range(0, 19) == 0) de[k] = -longint'($urandom_range(0, 300));
            end
            run_step(t % 7 == 3);
        end
        summary();
    end

endmodule